// File: doc/BRIEF.md
# PLL Serial Reconfiguration Sequencer

This block lets on-chip logic reprogram a PLL through its serial scan port. The user places a full configuration image on a parallel input, says which chain length the target PLL has, flags whether divider or loop-filter settings change, and pulses `start`. The sequencer copies the image, raises the scan enable one cycle ahead of the data, and shifts the image out least significant bit first. It then drops the enable, strobes the update line for one cycle and follows the PLL's done line through its rising and falling edges.

When the falling edge arrives, the counters hold the new values. If the loop-changed flag was set when the sequence was accepted, a reset pulse of fixed length goes to the PLL. A one-cycle completion pulse then ends the sequence. If the done line stays silent for too long in either wait, the block gives up, returns to idle and sets an error flag. The flag stays set until the next accepted start. The sequence can run any number of times, and all timing is counted in scan-clock cycles.

Top module: `pll_scan_sequencer`

## Requirements
- R1: While `rst_n` is low, and in the first cycle after it rises, `scan_en`, `scan_data`, `cfg_update`, `pll_reset`, `busy`, `seq_done` and `timeout_err` are all 0.
- R2: After an accepted start, `scan_en` is high for one lead cycle before bit D0 is presented. The PLL therefore captures D0 on the second rising edge that sees the enable high, and `scan_en` stays high for exactly chain length + 1 consecutive cycles.
- R3: The image goes out from bit 0 upward, one bit per cycle. With `long_chain` = 1 it sends exactly 234 bits and with `long_chain` = 0 exactly 180 bits (image bits 180..233 are never sent). `scan_enable` then goes low.
- R4: `cfg_update` is high for exactly one cycle per sequence. It follows at least one cycle in which `scan_en` is low, and it is never high together with `scan_en`.
- R5: After the update, the block waits for a rising edge and then a falling edge on `pll_done`. Without a reset it then pulses `seq_done` for one cycle with `busy` low.
- R6: If `loop_changed` was 1 at the accepted start, `pll_reset` is high for exactly RST_CYCLES (4) cycles after the falling edge of `pll_done`. `seq_done` pulses in the cycle `pll_reset` drops. With `loop_changed` = 0, `pll_reset` stays low.
- R7: If either wait on `pll_done` lasts WAIT_LIMIT (64) cycles without the awaited edge, the block returns to idle, sets `timeout_err`, and gives no `seq_done` and no `pll_reset`. `timeout_err` clears on the next accepted start.
- R8: While `busy` is high, `start`, `cfg_image`, `long_chain` and `loop_changed` have no effect on the shifted bits, the chain length or the reset decision.
- R9: Sequences may follow one another without limit, and each one behaves as in R2–R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Scan clock; all logic on its rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request a reconfiguration; accepted only when idle |
| cfg_image | input | LONG_LEN (234) | Configuration image, bit 0 shifted first |
| long_chain | input | 1 | 1 = 234-bit chain, 0 = 180-bit chain |
| loop_changed | input | 1 | 1 = divider or loop-filter settings change, reset the PLL afterwards |
| pll_done | input | 1 | PLL done line: rise = reprogramming started, fall = finished |
| scan_data | output | 1 | Serial data to the PLL scan chain |
| scan_en | output | 1 | Scan enable to the PLL |
| cfg_update | output | 1 | One-cycle strobe that loads the chain into the counters |
| pll_reset | output | 1 | Reset pulse to the PLL |
| busy | output | 1 | Sequence in progress |
| seq_done | output | 1 | One-cycle pulse on successful completion |
| timeout_err | output | 1 | Last sequence ended on a done-line timeout |

## Verification
Every cycle, the assertions check the handshake shape. The update strobe lasts one cycle and never overlaps the enable or follows it directly. The enable is held through its lead cycle. The reset pulse has its fixed length and coincides with the completion pulse when it ends. Completion and timeout both leave the block idle. Only the bench scenarios can show the serial content: that every image bit arrives at the PLL model in order, that the count matches the selected chain length, and that the lead cycle places D0 on the second capturing edge. They also show that requests and input changes during a sequence are ignored, and that the timeout paths fire on a silent or stuck done line.

// File: rtl/pll_scan_pkg.sv
// Shared types for the PLL scan sequencer.
// Assumes: nothing beyond SystemVerilog 2017.
package pll_scan_pkg;

    // Sequencer states, in the order the handshake visits them.
    typedef enum logic [2:0] {
        ST_IDLE      = 3'd0,
        ST_LEAD      = 3'd1,
        ST_SHIFT     = 3'd2,
        ST_GAP       = 3'd3,
        ST_UPDATE    = 3'd4,
        ST_WAIT_RISE = 3'd5,
        ST_WAIT_FALL = 3'd6,
        ST_RESET     = 3'd7
    } seq_state_t;

endpackage

// File: rtl/scan_shift_reg.sv
// Holds a copy of the configuration image and presents it one bit at a
// time, bit 0 first. It counts the bits advanced and flags the last one
// for the chain length latched at load.
// Assumes: load and advance are never high together.
module scan_shift_reg #(
    parameter int LONG_LEN  = 234,
    parameter int SHORT_LEN = 180
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                advance,
    input  logic [LONG_LEN-1:0] image,
    input  logic                long_sel,
    output logic                bit_out,
    output logic                last_bit
);
    localparam int CNT_W = $clog2(LONG_LEN);
    localparam logic [CNT_W-1:0] LAST_LONG  = CNT_W'(LONG_LEN - 1);
    localparam logic [CNT_W-1:0] LAST_SHORT = CNT_W'(SHORT_LEN - 1);

    logic [LONG_LEN-1:0] sreg;
    logic [CNT_W-1:0]    cnt;
    logic                long_q;
    logic [CNT_W-1:0]    end_idx;

    // Load the image on request, otherwise shift right and count.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sreg   <= '0;
            cnt    <= '0;
            long_q <= 1'b0;
        end else if (load) begin
            sreg   <= image;
            cnt    <= '0;
            long_q <= long_sel;
        end else if (advance) begin
            sreg <= {1'b0, sreg[LONG_LEN-1:1]};
            cnt  <= cnt + 1'b1;
        end
    end

    // Choose the final bit index; a single-length build needs no mux.
    generate
        if (SHORT_LEN == LONG_LEN) begin : g_one_len
            assign end_idx = LAST_LONG;
        end else begin : g_two_len
            assign end_idx = long_q ? LAST_LONG : LAST_SHORT;
        end
    endgenerate

    assign bit_out  = sreg[0];
    assign last_bit = (cnt == end_idx);

endmodule

// File: rtl/wait_timer.sv
// Counts the cycles spent waiting for an event and flags expiry once
// LIMIT cycles have passed since the last clear.
// Assumes: LIMIT >= 2.
module wait_timer #(
    parameter int LIMIT = 64
) (
    input  logic clk,
    input  logic rst_n,
    input  logic clr,
    output logic expired
);
    localparam int W = $clog2(LIMIT + 1);
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    // Count up while not cleared, holding at the expiry value.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            cnt <= '0;
        end else if (!expired) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign expired = (cnt == LAST);

endmodule

// File: rtl/done_edge_detect.sv
// Registers the PLL done line and reports its rising and falling edges
// in the cycle the new level is first seen.
// Assumes: done_in is synchronous to clk.
module done_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic done_in,
    output logic rise,
    output logic fall
);
    logic done_q;

    // Keep last cycle's level for edge comparison.
    always_ff @(posedge clk) begin
        if (!rst_n) done_q <= 1'b0;
        else        done_q <= done_in;
    end

    assign rise = done_in & ~done_q;
    assign fall = ~done_in & done_q;

endmodule

// File: rtl/pll_scan_sequencer.sv
// Top of the PLL scan sequencer. It accepts a start in idle, shifts the
// image after one enable lead cycle and leaves one idle cycle before a
// one-cycle update strobe. It then follows the done line's rise and fall,
// each under a timeout, and optionally pulses the PLL reset before
// reporting completion.
// Assumes: the PLL raises done no earlier than one cycle after the update.
module pll_scan_sequencer
    import pll_scan_pkg::*;
#(
    parameter int LONG_LEN   = 234,
    parameter int SHORT_LEN  = 180,
    parameter int RST_CYCLES = 4,
    parameter int WAIT_LIMIT = 64
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic [LONG_LEN-1:0] cfg_image,
    input  logic                long_chain,
    input  logic                loop_changed,
    input  logic                pll_done,
    output logic                scan_data,
    output logic                scan_en,
    output logic                cfg_update,
    output logic                pll_reset,
    output logic                busy,
    output logic                seq_done,
    output logic                timeout_err
);
    localparam int RW = $clog2(RST_CYCLES + 1);
    localparam logic [RW-1:0] RST_LAST = RW'(RST_CYCLES - 1);

    seq_state_t    state;
    logic          accept;
    logic          bit_out, last_bit;
    logic          d_rise, d_fall;
    logic          waiting, tmr_clr, tmr_expired;
    logic          chg_q, done_p, err_q;
    logic [RW-1:0] rst_cnt;

    assign accept  = start && (state == ST_IDLE);
    assign waiting = (state == ST_WAIT_RISE) || (state == ST_WAIT_FALL);
    assign tmr_clr = !waiting || ((state == ST_WAIT_RISE) && d_rise);

    scan_shift_reg #(
        .LONG_LEN  (LONG_LEN),
        .SHORT_LEN (SHORT_LEN)
    ) u_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (accept),
        .advance  (state == ST_SHIFT),
        .image    (cfg_image),
        .long_sel (long_chain),
        .bit_out  (bit_out),
        .last_bit (last_bit)
    );

    wait_timer #(
        .LIMIT (WAIT_LIMIT)
    ) u_timer (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (tmr_clr),
        .expired (tmr_expired)
    );

    done_edge_detect u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .done_in (pll_done),
        .rise    (d_rise),
        .fall    (d_fall)
    );

    // Step the handshake and keep the completion, error and reset flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= ST_IDLE;
            chg_q   <= 1'b0;
            done_p  <= 1'b0;
            err_q   <= 1'b0;
            rst_cnt <= '0;
        end else begin
            done_p <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (accept) begin
                        state <= ST_LEAD;
                        chg_q <= loop_changed;
                        err_q <= 1'b0;
                    end
                end
                ST_LEAD:   state <= ST_SHIFT;
                ST_SHIFT:  if (last_bit) state <= ST_GAP;
                ST_GAP:    state <= ST_UPDATE;
                ST_UPDATE: state <= ST_WAIT_RISE;
                ST_WAIT_RISE: begin
                    if (d_rise) begin
                        state <= ST_WAIT_FALL;
                    end else if (tmr_expired) begin
                        state <= ST_IDLE;
                        err_q <= 1'b1;
                    end
                end
                ST_WAIT_FALL: begin
                    if (d_fall) begin
                        if (chg_q) begin
                            state <= ST_RESET;
                        end else begin
                            state  <= ST_IDLE;
                            done_p <= 1'b1;
                        end
                    end else if (tmr_expired) begin
                        state <= ST_IDLE;
                        err_q <= 1'b1;
                    end
                end
                ST_RESET: begin
                    if (rst_cnt == RST_LAST) begin
                        state  <= ST_IDLE;
                        done_p <= 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase

            // Reset-length counter runs only inside the reset state.
            if (state == ST_RESET) rst_cnt <= rst_cnt + 1'b1;
            else                   rst_cnt <= '0;
        end
    end

    // Decode the port levels from the current state.
    always_comb begin
        scan_en     = (state == ST_LEAD) || (state == ST_SHIFT);
        scan_data   = scan_en && bit_out;
        cfg_update  = (state == ST_UPDATE);
        pll_reset   = (state == ST_RESET);
        busy        = (state != ST_IDLE);
        seq_done    = done_p;
        timeout_err = err_q;
    end

endmodule

// File: rtl/pll_scan_checker.sv
// Protocol checker for the PLL scan sequencer, bound to every instance.
// It watches the ports only and tracks reset-pulse length with a counter.
// Assumes: the same RST_CYCLES as the bound instance.
module pll_scan_checker #(
    parameter int RST_CYCLES = 4
) (
    input logic clk,
    input logic rst_n,
    input logic scan_en,
    input logic cfg_update,
    input logic pll_reset,
    input logic busy,
    input logic seq_done,
    input logic timeout_err
);
    int unsigned rst_run;

    // Length of the current run of pll_reset high.
    always_ff @(posedge clk) begin
        if (!rst_n)         rst_run <= 0;
        else if (pll_reset) rst_run <= rst_run + 1;
        else                rst_run <= 0;
    end

    assert_enable_lead_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(scan_en) |-> busy ##1 scan_en);

    assert_update_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |=> !cfg_update);

    assert_update_apart_R4: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_update |-> !scan_en);

    assert_update_gap_R4: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(scan_en) |-> !cfg_update);

    assert_done_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
        seq_done |-> !busy ##1 !seq_done);

    assert_reset_length_R6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pll_reset) |-> (seq_done && rst_run == RST_CYCLES));

    assert_reset_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
        pll_reset |-> (busy && rst_run < RST_CYCLES));

    assert_timeout_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(timeout_err) |-> (!busy && !seq_done && !pll_reset));

endmodule

bind pll_scan_sequencer pll_scan_checker #(
    .RST_CYCLES (RST_CYCLES)
) u_checker (
    .clk         (clk),
    .rst_n       (rst_n),
    .scan_en     (scan_en),
    .cfg_update  (cfg_update),
    .pll_reset   (pll_reset),
    .busy        (busy),
    .seq_done    (seq_done),
    .timeout_err (timeout_err)
);

// File: tb/tb_pll_scan_sequencer.sv
// Bench: sweeps chain length, reset flag, image pattern and done delay
// against a small PLL model. It then drives both timeout paths.
module tb_pll_scan_sequencer;
    localparam int LONG  = 234;
    localparam int SHORT = 180;
    localparam int RSTC  = 4;
    localparam int HOLD  = 3;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            start = 1'b0;
    logic [LONG-1:0] cfg_image = '0;
    logic            long_chain = 1'b0;
    logic            loop_changed = 1'b0;
    logic            pll_done = 1'b0;
    logic            scan_data, scan_en, cfg_update, pll_reset, busy, seq_done, timeout_err;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;
    int good_runs = 0;
    int want_runs = 0;

    // Model controls (written by tasks) and statistics (written by model).
    int run_id = 0, seen_id = 0;
    int rise_dly = 1;
    bit never_rise = 0, never_fall = 0;
    logic cap [0:255];
    int cap_cnt, en_run, en_cyc, gap, upd_cnt, rst_cyc, done_cnt, phase, cd;
    bit upd_seen;

    always #10 clk = ~clk;

    pll_scan_sequencer #(
        .LONG_LEN   (LONG),
        .SHORT_LEN  (SHORT),
        .RST_CYCLES (RSTC),
        .WAIT_LIMIT (64)
    ) dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_image    (cfg_image),
        .long_chain   (long_chain),
        .loop_changed (loop_changed),
        .pll_done     (pll_done),
        .scan_data    (scan_data),
        .scan_en      (scan_en),
        .cfg_update   (cfg_update),
        .pll_reset    (pll_reset),
        .busy         (busy),
        .seq_done     (seq_done),
        .timeout_err  (timeout_err)
    );

    // PLL model: samples at the falling edge (the level the next rising
    // edge captures) and drives the done line away from the rising edge.
    always @(negedge clk) begin
        if (run_id != seen_id) begin
            seen_id = run_id;
            cap_cnt = 0; en_run = 0; en_cyc = 0; gap = 0; upd_cnt = 0;
            rst_cyc = 0; done_cnt = 0; phase = 0; cd = 0; upd_seen = 0;
            pll_done = 1'b0;
        end
        if (scan_en) begin
            en_run = en_run + 1;
            en_cyc = en_cyc + 1;
            if (en_run >= 2) begin
                if (cap_cnt < 256) cap[cap_cnt] = scan_data;
                cap_cnt = cap_cnt + 1;
            end
        end else begin
            en_run = 0;
            if (en_cyc > 0 && !upd_seen && !cfg_update) gap = gap + 1;
        end
        if (cfg_update) begin
            upd_cnt = upd_cnt + 1;
            upd_seen = 1;
            cd = rise_dly;
            phase = 1;
        end else if (phase == 1) begin
            cd = cd - 1;
            if (cd == 0) begin
                if (!never_rise) begin
                    pll_done = 1'b1;
                    cd = HOLD;
                    phase = 2;
                end else begin
                    phase = 0;
                end
            end
        end else if (phase == 2 && !never_fall) begin
            cd = cd - 1;
            if (cd == 0) begin
                pll_done = 1'b0;
                phase = 0;
            end
        end
        if (pll_reset) rst_cyc = rst_cyc + 1;
        if (seq_done)  done_cnt = done_cnt + 1;
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic logic [LONG-1:0] pattern(input int p);
        logic [LONG-1:0] v;
        for (int i = 0; i < LONG; i++) begin
            case (p)
                0:       v[i] = 1'b1;
                1:       v[i] = i[0];
                2:       v[i] = ((i * 7 + 3) % 5) == 0;
                default: v[i] = (((i * i + i / 3) >> 1) & 1) == 1;
            endcase
        end
        return v;
    endfunction

    task automatic print_summary();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    // One sequence: apply inputs, start, disturb inputs, wait, then check.
    task automatic run_seq(input logic [LONG-1:0] img, input bit lng, input bit chg,
                           input int rdly, input bit nr, input bit nf, input bit inject);
        int len;
        int w;
        int mism;
        len = lng ? LONG : SHORT;
        @(posedge clk); #1;
        run_id++;
        rise_dly = rdly; never_rise = nr; never_fall = nf;
        cfg_image = img; long_chain = lng; loop_changed = chg;
        start = 1'b1;
        @(posedge clk); #1;
        start = 1'b0;
        // R8: changes after acceptance must not matter.
        cfg_image = ~img; long_chain = ~lng; loop_changed = ~chg;
        if (inject) begin
            repeat (20) @(posedge clk);
            #1 start = 1'b1;
            @(posedge clk); #1 start = 1'b0;
        end
        w = 0;
        while (busy && w < 3000) begin
            @(posedge clk); #1;
            w++;
        end
        chk(!busy, "R9 sequence ends", busy, 0);
        @(posedge clk); #1;
        if (!nr && !nf) begin
            want_runs++;
            mism = 0;
            for (int i = 0; i < len && i < 256; i++)
                if (cap[i] !== img[i]) mism++;
            chk(cap_cnt == len, "R3 bit count", cap_cnt, len);
            chk(mism == 0, inject ? "R8 bits unaffected" : "R3 bit order", mism, 0);
            chk(en_cyc == len + 1, "R2 enable lead", en_cyc, len + 1);
            chk(upd_cnt == 1, "R4 update width", upd_cnt, 1);
            chk(gap >= 1, "R4 idle before update", gap, 1);
            chk(rst_cyc == (chg ? RSTC : 0), "R6 reset length", rst_cyc, chg ? RSTC : 0);
            chk(done_cnt == 1, "R5 done pulse", done_cnt, 1);
            chk(timeout_err == 1'b0, "R7 error clear", timeout_err, 0);
            if (cap_cnt == len && mism == 0 && done_cnt == 1) good_runs++;
        end else begin
            chk(timeout_err == 1'b1, "R7 timeout flag", timeout_err, 1);
            chk(done_cnt == 0, "R7 no done", done_cnt, 0);
            chk(rst_cyc == 0, "R7 no reset", rst_cyc, 0);
        end
        start = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (150000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        print_summary();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        // R1: outputs quiet while reset is held.
        chk({scan_en, scan_data, cfg_update, pll_reset, busy, seq_done, timeout_err} == 7'b0,
            "R1 in reset", {scan_en, scan_data, cfg_update, pll_reset, busy, seq_done, timeout_err}, 0);
        rst_n = 1'b1;
        @(posedge clk); #1;
        chk({scan_en, scan_data, cfg_update, pll_reset, busy, seq_done, timeout_err} == 7'b0,
            "R1 after reset", {scan_en, scan_data, cfg_update, pll_reset, busy, seq_done, timeout_err}, 0);

        for (int lng = 0; lng < 2; lng++)
            for (int chg = 0; chg < 2; chg++)
                for (int p = 0; p < 4; p++)
                    for (int d = 0; d < 2; d++)
                        run_seq(pattern(p) ^ {LONG{d[0]}}, lng[0], chg[0],
                                d == 0 ? 1 : 6, 1'b0, 1'b0, p == 2);

        // R7: silent done line, then a done line stuck high.
        run_seq(pattern(3), 1'b1, 1'b1, 2, 1'b1, 1'b0, 1'b0);
        run_seq(pattern(1), 1'b0, 1'b1, 2, 1'b0, 1'b1, 1'b0);
        // R7: error clears on the next start; R9: normal run follows.
        run_seq(pattern(2), 1'b0, 1'b1, 3, 1'b0, 1'b0, 1'b0);

        chk(good_runs == want_runs, "R9 repeated runs", good_runs, want_runs);
        print_summary();
    end

endmodule